// File: doc/BRIEF.md
# Windowed Register File

This block is a register file with a large physical pool of registers. A procedure never addresses that pool directly. It sees a small window of consecutive physical registers, and it selects one register in that window with a short logical index. A window pointer supplies the offset. A call strobe slides the window up to a fresh, disjoint group. A return strobe slides it back down, so the caller finds its registers as it left them. No register contents travel to memory on either strobe. The pointer moves on the clock edge that samples the strobe.

There are two combinational read ports and one synchronous write port, all indexed by logical register number. A strobe that would push the window past either end of the pool is refused. The refusal is reported by a one-cycle overflow or underflow flag. Register contents are never initialised or cleared by reset. Software must write a register before it reads it.

Top module: `windowed_regfile`

## Requirements
- R1: Synchronous active-high reset sets the window offset to 0 and clears ovf_o and unf_o. After reset, logical index i addresses physical register i.
- R2: Each read port returns, in the same cycle and without a clock edge, the physical register at window offset plus its logical index, using the current offset.
- R3: With wr_en high, wr_data is stored at clock edge into the physical register at window offset plus wr_idx. Registers of other windows are unaffected.
- R4: A call strobe alone, with the offset below its top value (pool size minus window size, 120 by default), raises the offset by the window size (8) at that clock edge. The new window shares no register with the previous one.
- R5: A return strobe alone, with a nonzero offset, lowers the offset by the window size. The caller's registers then read back unchanged.
- R6: A call strobe alone at the top offset leaves the offset unchanged and drives ovf_o high for exactly the next cycle. Repeated refused calls pulse it again.
- R7: A return strobe alone at offset 0 leaves the offset unchanged and drives unf_o high for exactly the next cycle.
- R8: A write in the same cycle as a call or return lands in the window as it was before the move.
- R9: Call and return strobes high in the same cycle leave the offset unchanged and raise neither flag.
- R10: Reset does not alter the contents of any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Move window up one group |
| ret_i | input | 1 | Move window down one group |
| rd_a_idx | input | 3 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 3 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Logical index, write port |
| wr_data | input | 32 | Write data |
| ovf_o | output | 1 | One-cycle pulse: call refused at top of pool |
| unf_o | output | 1 | One-cycle pulse: return refused at bottom |

## Verification
Read data is combinational, so a read is checked a moment after its index settles, in the same half cycle. A write, a window move or a flag is due at the first rising edge after the stimulus is applied. The bench drives on the falling edge and samples on the next falling edge, after exactly one rising edge has occurred. Flag pulses are checked twice: on the falling edge right after the offending strobe, where they must be high, and on the following falling edge, where they must be low again.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  // Net effect of the strobes in one cycle
  typedef enum logic [2:0] {
    MV_HOLD   = 3'd0,
    MV_UP     = 3'd1,
    MV_DOWN   = 3'd2,
    MV_REF_UP = 3'd3,
    MV_REF_DN = 3'd4
  } move_e;
endpackage

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl
  import wrf_pkg::*;
#(
  parameter int NUM_PHYS = 128,
  parameter int WIN      = 8,
  localparam int AW      = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_i,
  input  logic          ret_i,
  output logic [AW-1:0] base_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [AW-1:0] TOP_BASE = AW'(NUM_PHYS - WIN);
  localparam logic [AW-1:0] STEP     = AW'(WIN);

  logic [AW-1:0] base_q;
  logic          ovf_q, unf_q;
  move_e         mv;

  always_comb begin
    mv = MV_HOLD;
    if (call_i && !ret_i)
      mv = (base_q == TOP_BASE) ? MV_REF_UP : MV_UP;
    else if (ret_i && !call_i)
      mv = (base_q == '0) ? MV_REF_DN : MV_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      ovf_q <= (mv == MV_REF_UP);
      unf_q <= (mv == MV_REF_DN);
      case (mv)
        MV_UP:   base_q <= base_q + STEP;
        MV_DOWN: base_q <= base_q - STEP;
        default: base_q <= base_q;
      endcase
    end
  end

  assign base_o = base_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;
endmodule

// File: rtl/wrf_xlate.sv
module wrf_xlate #(
  parameter int NUM_PHYS = 128,
  parameter int WIN      = 8,
  parameter int NPORT    = 3,
  localparam int AW      = $clog2(NUM_PHYS),
  localparam int LW      = $clog2(WIN)
) (
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] lidx_i [NPORT],
  output logic [AW-1:0] pidx_o [NPORT]
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign pidx_o[p] = base_i + {{(AW-LW){1'b0}}, lidx_i[p]};
  end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int NUM_PHYS = 128,
  parameter int DW       = 32,
  parameter int NRD      = 2,
  localparam int AW      = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [DW-1:0] rdata_o [NRD]
);
  logic [DW-1:0] mem [NUM_PHYS];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem[raddr_i[r]];
  end
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile #(
  parameter int NUM_PHYS = 128,
  parameter int WIN      = 8,
  parameter int DW       = 32,
  localparam int AW      = $clog2(NUM_PHYS),
  localparam int LW      = $clog2(WIN),
  localparam int NRD     = 2,
  localparam int NPORT   = NRD + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [LW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [LW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [AW-1:0] win_base;
  logic [LW-1:0] lidx [NPORT];
  logic [AW-1:0] pidx [NPORT];
  logic [AW-1:0] raddr [NRD];
  logic [DW-1:0] rdata [NRD];

  wrf_window_ctrl #(.NUM_PHYS(NUM_PHYS), .WIN(WIN)) u_win (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .base_o(win_base), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // port 0/1 are reads, last port is the write; all use the pre-move base
  assign lidx[0]     = rd_a_idx;
  assign lidx[1]     = rd_b_idx;
  assign lidx[NRD]   = wr_idx;

  wrf_xlate #(.NUM_PHYS(NUM_PHYS), .WIN(WIN), .NPORT(NPORT)) u_xl (
    .base_i(win_base), .lidx_i(lidx), .pidx_o(pidx)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_ra
    assign raddr[r] = pidx[r];
  end

  wrf_storage #(.NUM_PHYS(NUM_PHYS), .DW(DW), .NRD(NRD)) u_mem (
    .clk(clk), .we_i(wr_en), .waddr_i(pidx[NRD]), .wdata_i(wr_data),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int NUM_PHYS = 128,
  parameter int WIN      = 8,
  localparam int AW      = $clog2(NUM_PHYS)
) (
  input logic          clk,
  input logic          rst,
  input logic          call_i,
  input logic          ret_i,
  input logic          ovf_o,
  input logic          unf_o,
  input logic [AW-1:0] base_i
);
  localparam logic [AW-1:0] TOP_BASE = AW'(NUM_PHYS - WIN);
  localparam logic [AW-1:0] STEP     = AW'(WIN);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (base_i == '0) && !ovf_o && !unf_o); // R1
  AST_CALL_STEPS: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && base_i != TOP_BASE) |=> base_i == $past(base_i) + STEP); // R4
  AST_RET_STEPS: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && base_i != '0) |=> base_i == $past(base_i) - STEP); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && base_i == TOP_BASE) |=> $stable(base_i) && ovf_o); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(call_i && !ret_i)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && base_i == '0) |=> $stable(base_i) && unf_o); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_o, unf_o})); // R7
  AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (call_i && ret_i) |=> $stable(base_i) && !ovf_o && !unf_o); // R9
endmodule

bind windowed_regfile wrf_checker #(.NUM_PHYS(NUM_PHYS), .WIN(WIN)) u_chk (
  .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
  .ovf_o(ovf_o), .unf_o(unf_o), .base_i(win_base)
);

// File: tb/tb_windowed_regfile.sv
module tb_windowed_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_i = 1'b0, ret_i = 1'b0;
  logic [2:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0;
  logic        ovf_o, unf_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  windowed_regfile dut (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // op: 0 write, 1 read check, 2 call, 3 return
  localparam int NV = 16;
  localparam logic [36:0] VECS [NV] = '{
    {2'd0, 3'd0, 32'h0000_0011},
    {2'd0, 3'd7, 32'h0000_0017},
    {2'd1, 3'd0, 32'h0000_0011},
    {2'd1, 3'd7, 32'h0000_0017},
    {2'd2, 3'd0, 32'h0},
    {2'd0, 3'd0, 32'h0000_0021},
    {2'd0, 3'd7, 32'h0000_0027},
    {2'd1, 3'd0, 32'h0000_0021},
    {2'd1, 3'd7, 32'h0000_0027},
    {2'd3, 3'd0, 32'h0},
    {2'd1, 3'd0, 32'h0000_0011},
    {2'd1, 3'd7, 32'h0000_0017},
    {2'd2, 3'd0, 32'h0},
    {2'd1, 3'd0, 32'h0000_0021},
    {2'd3, 3'd0, 32'h0},
    {2'd1, 3'd7, 32'h0000_0017}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_move(input logic c, input logic r);
    call_i = c; ret_i = r;
    tick();
    call_i = 1'b0; ret_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] i, input logic [31:0] exp);
    rd_a_idx = i; rd_b_idx = i;
    #1;
    check({req, " port A"}, rd_a_data, exp);
    check({req, " port B"}, rd_b_data, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    check("R1 ovf after reset", {31'd0, ovf_o}, 32'd0);
    check("R1 unf after reset", {31'd0, unf_o}, 32'd0);

    // table walk: R2 R3 reads/writes, R4 call isolation, R5 return restores
    for (int v = 0; v < NV; v++) begin
      case (VECS[v][36:35])
        2'd0: do_write(VECS[v][34:32], VECS[v][31:0]);
        2'd1: rd_check("R2/R3/R4/R5 table", VECS[v][34:32], VECS[v][31:0]);
        2'd2: do_move(1'b1, 1'b0);
        default: do_move(1'b0, 1'b1);
      endcase
    end

    // climb to the top window (offset 120)
    for (int k = 0; k < 15; k++) do_move(1'b1, 1'b0);
    check("R4 no ovf on legal call", {31'd0, ovf_o}, 32'd0);
    do_write(3'd3, 32'h0000_0ABC);
    do_move(1'b1, 1'b0);
    check("R6 ovf pulse", {31'd0, ovf_o}, 32'd1);
    check("R6 no unf", {31'd0, unf_o}, 32'd0);
    tick();
    check("R6 ovf drops", {31'd0, ovf_o}, 32'd0);
    rd_check("R6 window held", 3'd3, 32'h0000_0ABC);

    // write with return in the same cycle lands in the old window
    wr_en = 1'b1; wr_idx = 3'd4; wr_data = 32'h0000_0044; ret_i = 1'b1;
    tick();
    wr_en = 1'b0; ret_i = 1'b0;
    do_move(1'b1, 1'b0);
    rd_check("R8 write before move", 3'd4, 32'h0000_0044);

    // simultaneous strobes cancel
    do_move(1'b1, 1'b1);
    check("R9 no ovf", {31'd0, ovf_o}, 32'd0);
    check("R9 no unf", {31'd0, unf_o}, 32'd0);
    rd_check("R9 window unchanged", 3'd3, 32'h0000_0ABC);

    // reset keeps contents, offset back to 0
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1 ovf cleared", {31'd0, ovf_o}, 32'd0);
    rd_check("R10 contents kept, R1 offset 0", 3'd0, 32'h0000_0011);

    // underflow at offset 0
    do_move(1'b0, 1'b1);
    check("R7 unf pulse", {31'd0, unf_o}, 32'd1);
    check("R7 no ovf", {31'd0, ovf_o}, 32'd0);
    tick();
    check("R7 unf drops", {31'd0, unf_o}, 32'd0);
    rd_check("R7 window held", 3'd7, 32'h0000_0017);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule